// File: doc/BRIEF.md
# Register-Mapped Reconfiguration Port Bridge

This block is a word-addressed register slave. It lets a processor reach the 16-bit dynamic reconfiguration port of a clock-synthesis primitive. Software writes one packed control word. That word holds a launch bit, a direction bit, a 7-bit port address and 16 bits of write data, and it starts exactly one port transaction.

While the transaction is in flight, a busy flag reads as set in the status word. Software polls that flag. Once it clears, the low half of the status word holds the value returned by the last read transaction.

A separate reset/enable register drives two level outputs. One releases the general reset of the clock logic and the other enables the synthesis primitive. Masked read-modify-write is done by software as a read followed by a write.

Top module: `drp_bridge`

## Requirements
- R1: Writing the register at byte offset 0x40 (word address 0x10) sets output gen_run_o from data bit 0 and synth_en_o from data bit 1, visible from the clock after the write; a read returns these two bits in bits 1:0.
- R2: The control register at byte offset 0x70 (word 0x1C) holds bit 29 = launch, bit 28 = 1 for read and 0 for write, bits 22:16 = port address, bits 15:0 = write data; bits 27:23 have no effect on the port address.
- R3: The status register at byte offset 0x74 (word 0x1D) returns bit 16 = busy, bits 15:0 = last read data, and all other bits zero.
- R4: Busy reads 1 from the clock after a launching control write until the clock on which drp_rdy_i is sampled high while waiting.
- R5: A launch drives drp_en_o high for exactly one clock, with drp_addr_o equal to the port address; for a write, drp_we_o is high in that same clock and drp_wdata_o carries the write data; for a read, drp_we_o stays low.
- R6: Read data is captured from drp_rdata_i on the completing drp_rdy_i of a read; a write transaction leaves the status read data unchanged.
- R7: A control write while busy is ignored: no second transaction starts and the control readback keeps its earlier value.
- R8: A control write with bit 29 clear starts no transaction, but the control register reads back the written word.
- R9: Word addresses other than 0x10, 0x1C and 0x1D read as zero, and writes to them change no register.
- R10: rst_ni low clears busy, the read data, the control register and both reset/enable outputs, even in the middle of a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write word address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | ADDR_W | Register read word address |
| rd_data_o | output | 32 | Register read data (combinational) |
| gen_run_o | output | 1 | Reset release for the clock logic |
| synth_en_o | output | 1 | Clock primitive enable |
| drp_en_o | output | 1 | Port enable strobe |
| drp_we_o | output | 1 | Port write enable |
| drp_addr_o | output | 7 | Port address |
| drp_wdata_o | output | 16 | Port write data |
| drp_rdata_i | input | 16 | Port read data |
| drp_rdy_i | input | 1 | Port completion strobe |

## Verification
A stuck or wrongly sequenced transaction state shows at the ports within a few clocks. It appears as a second enable strobe, a missing strobe, or a busy bit that never clears, and the poll limit catches the last case. A wrong address or data path shows as a mismatch on the next readback in the sweep over all 128 port addresses. A late or misplaced capture register shows as stale status data on the first read after a write. Reset mid-transaction is checked by reading the status word on the clock after release.

// File: rtl/drp_bridge_pkg.sv
package drp_bridge_pkg;
  localparam int unsigned DRP_AW = 7;
  localparam int unsigned DRP_DW = 16;

  localparam int unsigned OFS_RESET = 32'h40;
  localparam int unsigned OFS_CTRL  = 32'h70;
  localparam int unsigned OFS_STAT  = 32'h74;

  localparam int unsigned CTRL_SEL_BIT  = 29;
  localparam int unsigned CTRL_RD_BIT   = 28;
  localparam int unsigned CTRL_ADDR_LSB = 16;
  localparam int unsigned STAT_BUSY_BIT = 16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } txn_state_e;

  typedef struct packed {
    logic              is_read;
    logic [DRP_AW-1:0] addr;
    logic [DRP_DW-1:0] data;
  } txn_req_t;

  function automatic txn_req_t unpack_ctrl(input logic [31:0] w);
    txn_req_t r;
    r.is_read = w[CTRL_RD_BIT];
    r.addr    = w[CTRL_ADDR_LSB +: DRP_AW];
    r.data    = w[DRP_DW-1:0];
    return r;
  endfunction
endpackage

// File: rtl/drp_bridge_regs.sv
module drp_bridge_regs
  import drp_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [31:0]       rd_data_o,
  input  logic              busy_i,
  input  logic [DRP_DW-1:0] rdata_i,
  output logic              launch_o,
  output txn_req_t          req_o,
  output logic              gen_run_o,
  output logic              synth_en_o
);
  localparam logic [ADDR_W-1:0] WA_RESET = ADDR_W'(OFS_RESET >> 2);
  localparam logic [ADDR_W-1:0] WA_CTRL  = ADDR_W'(OFS_CTRL >> 2);
  localparam logic [ADDR_W-1:0] WA_STAT  = ADDR_W'(OFS_STAT >> 2);

  logic [1:0]  rst_q;
  logic [31:0] ctrl_q;
  logic        ctrl_acc;

  // control writes while a transaction runs are dropped entirely
  assign ctrl_acc = wr_en_i && (wr_addr_i == WA_CTRL) && !busy_i;
  assign launch_o = ctrl_acc && wr_data_i[CTRL_SEL_BIT];
  assign req_o    = unpack_ctrl(wr_data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_en_i && (wr_addr_i == WA_RESET)) rst_q <= wr_data_i[1:0];
      if (ctrl_acc) ctrl_q <= wr_data_i;
    end
  end

  assign gen_run_o  = rst_q[0];
  assign synth_en_o = rst_q[1];

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      WA_RESET: rd_data_o = {30'd0, rst_q};
      WA_CTRL:  rd_data_o = ctrl_q;
      WA_STAT: begin
        rd_data_o[STAT_BUSY_BIT] = busy_i;
        rd_data_o[DRP_DW-1:0]    = rdata_i;
      end
      default:  rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/drp_bridge_txn.sv
module drp_bridge_txn
  import drp_bridge_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  txn_req_t          req_i,
  output logic              busy_o,
  output logic [DRP_DW-1:0] rdata_o,
  output logic              drp_en_o,
  output logic              drp_we_o,
  output logic [DRP_AW-1:0] drp_addr_o,
  output logic [DRP_DW-1:0] drp_wdata_o,
  input  logic [DRP_DW-1:0] drp_rdata_i,
  input  logic              drp_rdy_i
);
  txn_state_e        state_q;
  txn_req_t          req_q;
  logic [DRP_DW-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      req_q   <= '0;
      rdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (launch_i) begin
          state_q <= ST_ISSUE;
          req_q   <= req_i;
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: if (drp_rdy_i) begin
          state_q <= ST_IDLE;
          if (req_q.is_read) rdata_q <= drp_rdata_i;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign rdata_o     = rdata_q;
  assign drp_en_o    = (state_q == ST_ISSUE);
  assign drp_we_o    = (state_q == ST_ISSUE) && !req_q.is_read;
  assign drp_addr_o  = req_q.addr;
  assign drp_wdata_o = req_q.data;
endmodule

// File: rtl/drp_bridge.sv
module drp_bridge
  import drp_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [31:0]       rd_data_o,
  output logic              gen_run_o,
  output logic              synth_en_o,
  output logic              drp_en_o,
  output logic              drp_we_o,
  output logic [6:0]        drp_addr_o,
  output logic [15:0]       drp_wdata_o,
  input  logic [15:0]       drp_rdata_i,
  input  logic              drp_rdy_i
);
  logic              busy;
  logic              launch;
  txn_req_t          req;
  logic [DRP_DW-1:0] rd_q;

  drp_bridge_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o),
    .busy_i     (busy),
    .rdata_i    (rd_q),
    .launch_o   (launch),
    .req_o      (req),
    .gen_run_o  (gen_run_o),
    .synth_en_o (synth_en_o)
  );

  drp_bridge_txn u_txn (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (launch),
    .req_i       (req),
    .busy_o      (busy),
    .rdata_o     (rd_q),
    .drp_en_o    (drp_en_o),
    .drp_we_o    (drp_we_o),
    .drp_addr_o  (drp_addr_o),
    .drp_wdata_o (drp_wdata_o),
    .drp_rdata_i (drp_rdata_i),
    .drp_rdy_i   (drp_rdy_i)
  );
endmodule

// File: rtl/drp_bridge_chk.sv
module drp_bridge_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy,
  input logic              den,
  input logic              dwe,
  input logic              rdy,
  input logic [15:0]       rdata,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              run,
  input logic              en
);
  assert_den_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    den |=> !den);
  assert_dwe_with_den_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dwe |-> den);
  assert_busy_at_den_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    den |-> busy);
  assert_busy_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !rdy) |=> busy);
  assert_no_launch_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> !den);
  assert_rdata_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy |=> $stable(rdata));
  assert_reset_follow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && wr_addr == ADDR_W'(8'h10)) |=> ({en, run} == $past(wr_data[1:0])));
endmodule

bind drp_bridge drp_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .busy    (busy),
  .den     (drp_en_o),
  .dwe     (drp_we_o),
  .rdy     (drp_rdy_i),
  .rdata   (rd_q),
  .wr_en   (wr_en_i),
  .wr_addr (wr_addr_i),
  .wr_data (wr_data_i),
  .run     (gen_run_o),
  .en      (synth_en_o)
);

// File: tb/drp_bridge_tb.sv
`timescale 1ns/1ps
module drp_bridge_tb;
  localparam int AW = 8;
  localparam logic [AW-1:0] A_RST = 8'h10, A_CTRL = 8'h1C, A_STAT = 8'h1D;

  logic clk = 0, rst_ni = 0;
  logic wr_en = 0;
  logic [AW-1:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic gen_run, synth_en, den, dwe, drdy = 0;
  logic [6:0] daddr;
  logic [15:0] dwdata, drdata = 0;

  int checks = 0, fails = 0, den_cnt = 0, lat = 1;
  logic [6:0] last_addr;
  logic last_we;
  logic [15:0] last_wd;
  logic [15:0] mem [128];

  drp_bridge #(.ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .gen_run_o(gen_run), .synth_en_o(synth_en), .drp_en_o(den), .drp_we_o(dwe),
    .drp_addr_o(daddr), .drp_wdata_o(dwdata), .drp_rdata_i(drdata), .drp_rdy_i(drdy));

  always #10 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial forever begin
    @(negedge clk);
    if (den) den_cnt++;
  end

  // stand-in for the clock primitive's port
  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 16'h0;
    forever begin
      @(negedge clk);
      if (den) begin
        int l;
        l = lat;
        last_addr = daddr; last_we = dwe; last_wd = dwdata;
        if (dwe) mem[daddr] = dwdata;
        repeat (l) @(negedge clk);
        drdata = mem[last_addr];
        drdy = 1;
        @(negedge clk);
        drdy = 0;
        drdata = 16'hDEAD;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 100; i++) begin
      bus_rd(A_STAT, s);
      if (!s[16]) return;
      @(negedge clk);
    end
    chk("R4 busy clears", 32'd1, 32'd0);
  endtask

  function automatic logic [15:0] pat(input int a);
    return 16'(a * 16'h0101) ^ 16'h5A3C;
  endfunction

  function automatic logic [31:0] ctrl(input logic rd, input int a, input logic [15:0] d);
    return (32'd1 << 29) | (32'(rd) << 28) | (32'(a & 127) << 16) | 32'(d);
  endfunction

  logic [31:0] v;
  int c0;

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R10 reset state
    bus_rd(A_STAT, v); chk("R10 status after reset", v, 0);
    bus_rd(A_CTRL, v); chk("R10 ctrl after reset", v, 0);
    chk("R10 outputs after reset", {30'd0, synth_en, gen_run}, 0);
    chk("R5 no enable after reset", {31'd0, den}, 0);

    // R1 reset register, all four combinations
    for (int k = 0; k < 4; k++) begin
      bus_wr(A_RST, 32'hFFFF_FFF0 | k);
      chk("R1 outputs", {30'd0, synth_en, gen_run}, k);
      bus_rd(A_RST, v); chk("R1 readback", v, k);
    end

    // R2 R5 write sweep over all port addresses
    for (int a = 0; a < 128; a++) begin
      lat = 1 + (a % 4);
      c0 = den_cnt;
      bus_wr(A_CTRL, ctrl(0, a, pat(a)));
      bus_rd(A_STAT, v); chk("R4 busy after launch", {31'd0, v[16]}, 1);
      wait_idle();
      chk("R5 one enable per write", den_cnt - c0, 1);
      chk("R5 write address", {25'd0, last_addr}, a);
      chk("R5 write strobe and data", {15'd0, last_we, last_wd}, {15'd0, 1'b1, pat(a)});
    end

    // R6 read sweep
    for (int a = 0; a < 128; a++) begin
      lat = 1 + ((a * 3) % 4);
      c0 = den_cnt;
      bus_wr(A_CTRL, ctrl(1, a, 16'hFFFF));
      wait_idle();
      chk("R5 one enable per read, no dwe", {den_cnt - c0, 31'(last_we)}, {32'd1, 31'd0});
      bus_rd(A_STAT, v); chk("R6 R3 read data", v, {16'd0, pat(a)});
    end

    // R6 write leaves read data unchanged
    bus_wr(A_CTRL, ctrl(0, 3, 16'h1234)); wait_idle();
    bus_rd(A_STAT, v); chk("R6 data kept over write", v, {16'd0, pat(127)});

    // R2 bits 27:23 ignored for address
    bus_wr(A_CTRL, ctrl(0, 9, 16'hBEEF) | 32'h0F80_0000); wait_idle();
    chk("R2 high bits ignored", {25'd0, last_addr}, 9);
    bus_wr(A_CTRL, ctrl(1, 9, 16'h0)); wait_idle();
    bus_rd(A_STAT, v); chk("R2 read of aliased write", v, 32'h0000_BEEF);

    // R7 control write while busy
    lat = 6;
    c0 = den_cnt;
    bus_wr(A_CTRL, ctrl(1, 5, 16'h0));
    bus_wr(A_CTRL, ctrl(0, 11, 16'hAAAA));
    wait_idle();
    chk("R7 single transaction", den_cnt - c0, 1);
    chk("R7 address of first", {25'd0, last_addr}, 5);
    bus_rd(A_CTRL, v); chk("R7 ctrl readback kept", v, ctrl(1, 5, 16'h0));
    lat = 2;
    bus_wr(A_CTRL, ctrl(1, 11, 16'h0)); wait_idle();
    bus_rd(A_STAT, v); chk("R7 target untouched", v, {16'd0, pat(11)});

    // R8 select clear
    c0 = den_cnt;
    bus_wr(A_CTRL, 32'h0001_5555);
    repeat (8) @(negedge clk);
    chk("R8 no transaction", den_cnt - c0, 0);
    bus_rd(A_CTRL, v); chk("R8 ctrl readback", v, 32'h0001_5555);
    bus_rd(A_STAT, v); chk("R8 status unchanged", v, {16'd0, pat(11)});

    // R9 unmapped
    bus_wr(A_RST, 32'h1);
    for (int a = 0; a < 256; a += 7) begin
      if (a == A_RST || a == A_CTRL || a == A_STAT) continue;
      bus_wr(AW'(a), 32'hFFFF_FFFF);
      bus_rd(AW'(a), v); chk("R9 unmapped reads zero", v, 0);
    end
    bus_rd(A_RST, v); chk("R9 reset reg unchanged", v, 1);
    bus_rd(A_CTRL, v); chk("R9 ctrl unchanged", v, 32'h0001_5555);

    // R10 reset during a transaction
    bus_wr(A_RST, 32'h3);
    lat = 6;
    bus_wr(A_CTRL, ctrl(1, 20, 16'h0));
    @(negedge clk);
    rst_ni = 0;
    @(negedge clk);
    rst_ni = 1;
    bus_rd(A_STAT, v); chk("R10 busy and data cleared", v, 0);
    chk("R10 outputs cleared", {30'd0, synth_en, gen_run}, 0);
    repeat (12) @(negedge clk);
    bus_rd(A_STAT, v); chk("R10 late ready ignored", v, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule